// File: doc/BRIEF.md
# Conversion-Start Controller for a Sampling Converter

This block is the digital control core of a successive-approximation converter. It watches two active-low command inputs, chip-select and read/convert. When both have been low long enough, it opens a conversion. While the conversion runs it holds an active-low busy flag. It then captures the finished word into a result register. The analog sample-hold and comparator are not modelled. A fixed-length counter stands in for the conversion time, and a test input supplies the word that the conversion produces.

Every asynchronous input passes through a two-flop synchronizer. Commands that arrive while busy is low are dropped. A command that is still held when busy returns high opens the next conversion immediately. A continuous mode keeps conversions running back to back. A power-down input holds off every new conversion. The block also counts the cycles between conversion starts and raises a flag when a start arrives before the acquisition spacing has elapsed.

Top module: `adc_start_ctrl`

## Requirements
- R1: A conversion starts when chip-select and read/convert, after synchronization, are both low for QUAL_CYC consecutive clocks. Either input may fall first.
- R2: A joint low level shorter than QUAL_CYC clocks starts nothing, and busy stays high.
- R3: `start_pulse` is high only while `busy_n` is high. The cycle after it, `busy_n` goes low and stays low for exactly CONV_CYC clocks.
- R4: On the edge where `busy_n` returns high, `result` takes the value of `test_word`. At every other edge it holds its value.
- R5: A command that falls and is released entirely while `busy_n` is low causes no extra conversion.
- R6: If both command inputs are still low when `busy_n` returns high, a new start occurs in that first idle cycle.
- R7: `early_cmd` pulses together with a start when fewer than SPACING_CYC clocks have passed since the previous start. It never pulses on the first start after reset.
- R8: A falling edge of chip-select or read/convert while `cont_en` is high enters continuous mode. In continuous mode a start is issued in every idle cycle. Driving `cont_en` low leaves the mode, and the conversion in progress still completes.
- R9: While the synchronized `pwr_dn` is high no start occurs, and `result` keeps its last value.
- R10: After reset, `busy_n` is 1, `result` is 0, and `start_pulse` and `early_cmd` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip-select, active low, asynchronous |
| rc_n | input | 1 | Read/convert, low requests conversion, asynchronous |
| cont_en | input | 1 | Continuous-conversion enable, asynchronous |
| pwr_dn | input | 1 | Power-down, high blocks new conversions, asynchronous |
| test_word | input | RES_W | Word captured as the conversion result |
| busy_n | output | 1 | Low while a conversion runs |
| start_pulse | output | 1 | One-cycle strobe at each conversion start |
| early_cmd | output | 1 | Start arrived before the spacing window elapsed |
| result | output | RES_W | Last completed conversion result |

## Verification
The bench builds the block with QUAL_CYC = 3, CONV_CYC = 8 and SPACING_CYC = 20. With these values a retriggered conversion, whose start gap is CONV_CYC + 1 = 9 clocks, falls inside the spacing window, while commands separated by about thirty clocks fall outside it. A command held for two clocks is visibly shorter than the qualifying window. A command pulse placed inside a conversion can also be released before busy returns, so the ignore, retrigger and continuous paths are each reached in a few dozen cycles.

// File: rtl/adc_start_ctrl.sv
module adc_start_ctrl #(
  parameter int RES_W       = 12,
  parameter int QUAL_CYC    = 8,
  parameter int CONV_CYC    = 64,
  parameter int SPACING_CYC = 5000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rc_n,
  input  logic             cont_en,
  input  logic             pwr_dn,
  input  logic [RES_W-1:0] test_word,
  output logic             busy_n,
  output logic             start_pulse,
  output logic             early_cmd,
  output logic [RES_W-1:0] result
);
  localparam int QW = $clog2(QUAL_CYC + 1);
  localparam int CW = $clog2(CONV_CYC + 1);
  localparam int SW = $clog2(SPACING_CYC + 1);
  localparam logic [QW-1:0] Q_MAX  = QW'(QUAL_CYC);
  localparam logic [QW-1:0] Q_LAST = QW'(QUAL_CYC - 1);
  localparam logic [CW-1:0] C_LAST = CW'(CONV_CYC - 1);
  localparam logic [SW-1:0] S_MAX  = SW'(SPACING_CYC);

  logic [2:0] cs_sr, rc_sr;
  logic [1:0] ct_sr, pd_sr;
  logic [QW-1:0] qcnt;
  logic [CW-1:0] ccnt;
  logic [SW-1:0] scnt;
  logic cont_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sr <= '1;
      rc_sr <= '1;
      ct_sr <= '0;
      pd_sr <= '0;
    end else begin
      cs_sr <= {cs_sr[1:0], cs_n};
      rc_sr <= {rc_sr[1:0], rc_n};
      ct_sr <= {ct_sr[0], cont_en};
      pd_sr <= {pd_sr[0], pwr_dn};
    end
  end

  wire req       = ~cs_sr[1] & ~rc_sr[1];
  wire cmd_fall  = (cs_sr[2] & ~cs_sr[1]) | (rc_sr[2] & ~rc_sr[1]);
  wire qualified = req && (qcnt >= Q_LAST);

  assign start_pulse = busy_n & ~pd_sr[1] & (qualified | cont_run);
  assign early_cmd   = start_pulse && (scnt != '0) && (scnt < S_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            qcnt <= '0;
    else if (!req)         qcnt <= '0;
    else if (qcnt != Q_MAX) qcnt <= qcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cont_run <= 1'b0;
    else if (!ct_sr[1]) cont_run <= 1'b0;
    else if (cmd_fall)  cont_run <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_n <= 1'b1;
      ccnt   <= '0;
      result <= '0;
    end else if (start_pulse) begin
      busy_n <= 1'b0;
      ccnt   <= '0;
    end else if (!busy_n) begin
      if (ccnt == C_LAST) begin
        busy_n <= 1'b1;
        result <= test_word;
      end else begin
        ccnt <= ccnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              scnt <= '0;
    else if (start_pulse)                    scnt <= SW'(1);
    else if (scnt != '0 && scnt != S_MAX)    scnt <= scnt + 1'b1;
  end
endmodule

module adc_start_ctrl_chk #(
  parameter int RES_W    = 12,
  parameter int CONV_CYC = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy_n,
  input logic             start_pulse,
  input logic             early_cmd,
  input logic             pdn_s,
  input logic [RES_W-1:0] result
);
  int lowcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lowcnt <= 0;
    else if (busy_n) lowcnt <= 0;
    else             lowcnt <= lowcnt + 1;
  end

  a_r3_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> busy_n);
  a_r3_busy_follows: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !busy_n);
  a_r3_low_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n |-> lowcnt < CONV_CYC);
  a_r3_low_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_n && lowcnt == CONV_CYC - 1) |=> busy_n);
  a_r4_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy_n) |-> $stable(result));
  a_r7_early_with_start: assert property (@(posedge clk) disable iff (!rst_n)
    early_cmd |-> start_pulse);
  a_r9_pdn_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    pdn_s |-> !start_pulse);
endmodule

bind adc_start_ctrl adc_start_ctrl_chk #(.RES_W(RES_W), .CONV_CYC(CONV_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_n(busy_n), .start_pulse(start_pulse),
  .early_cmd(early_cmd), .pdn_s(pd_sr[1]), .result(result)
);

// File: tb/adc_start_ctrl_test.sv
`timescale 1ns/1ps
module adc_start_ctrl_test;
  localparam int QC = 3, CC = 8, SC = 20;

  logic clk = 0, rst_n = 0, cs_n = 1, rc_n = 1, cont_en = 0, pwr_dn = 0;
  logic [11:0] test_word = '0;
  logic busy_n, start_pulse, early_cmd;
  logic [11:0] result;

  adc_start_ctrl #(.RES_W(12), .QUAL_CYC(QC), .CONV_CYC(CC), .SPACING_CYC(SC)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rc_n(rc_n), .cont_en(cont_en),
    .pwr_dn(pwr_dn), .test_word(test_word), .busy_n(busy_n),
    .start_pulse(start_pulse), .early_cmd(early_cmd), .result(result));

  always #2.5 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  int starts = 0, rises = 0, earlies = 0, lowlen = 0;
  bit prev_busy = 1, prev_start = 0, done = 0;
  logic [11:0] expq[$];

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(logic [11:0] w);
    expq.push_back(w);
  endtask

  // monitor / scoreboard
  always @(negedge clk) if (rst_n) begin
    if (start_pulse) starts++;
    if (early_cmd) earlies++;
    if (prev_start) chk("R3 busy low after start", busy_n, 0);
    if (!busy_n) lowlen++;
    else if (!prev_busy) begin
      rises++;
      chk("R3 busy low length", lowlen, CC);
      lowlen = 0;
      if (expq.size() == 0) chk("R4 unexpected conversion", 1, 0);
      else chk("R4 result word", result, expq.pop_front());
    end
    prev_busy  = busy_n;
    prev_start = start_pulse;
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
    end
  end

  initial begin
    int s0, r0, e0;
    cyc(4);
    rst_n = 1;
    cyc(1);
    chk("R10 busy_n", busy_n, 1);
    chk("R10 result", result, 0);
    chk("R10 start", start_pulse, 0);
    chk("R10 early", early_cmd, 0);

    // R1 chip-select falls first
    test_word = 12'hA5C; push(12'hA5C);
    cs_n = 0; cyc(5); rc_n = 0; cyc(QC + 2); rc_n = 1; cs_n = 1; cyc(30);
    chk("R1 cs-first start count", starts, 1);
    chk("R4 result after cs-first", result, 12'hA5C);

    // R1 read/convert falls first
    test_word = 12'h3C1; push(12'h3C1);
    rc_n = 0; cyc(4); cs_n = 0; cyc(QC + 2); cs_n = 1; rc_n = 1; cyc(30);
    chk("R1 rc-first start count", starts, 2);

    // R2 too short
    s0 = starts;
    cs_n = 0; rc_n = 0; cyc(QC - 1); cs_n = 1; rc_n = 1; cyc(20);
    chk("R2 no start", starts, s0);
    chk("R2 busy high", busy_n, 1);
    chk("R2 result kept", result, 12'h3C1);

    // R5 command during busy ignored
    test_word = 12'h7E2; push(12'h7E2);
    cs_n = 0; rc_n = 0; cyc(QC + 2); cs_n = 1; cyc(1); cs_n = 0; cyc(2);
    cs_n = 1; rc_n = 1; cyc(30);
    chk("R5 single conversion", starts, s0 + 1);
    test_word = 12'hFFF; cyc(10);
    chk("R4 result holds while idle", result, 12'h7E2);

    // R6 retrigger, R7 early flag
    s0 = starts; e0 = earlies;
    test_word = 12'h155; push(12'h155); push(12'h155);
    cs_n = 0; rc_n = 0; cyc(QC + CC + 3); cs_n = 1; rc_n = 1; cyc(40);
    chk("R6 retrigger starts", starts, s0 + 2);
    chk("R7 early flag on retrigger", earlies, e0 + 1);

    // R8 continuous mode
    s0 = starts; r0 = rises; e0 = earlies;
    test_word = 12'h2AA; push(12'h2AA); push(12'h2AA); push(12'h2AA);
    cont_en = 1; cyc(3); rc_n = 0;
    wait (rises == r0 + 2);
    cyc(1); cont_en = 0; rc_n = 1; cyc(40);
    chk("R8 continuous conversions", rises, r0 + 3);
    chk("R8 continuous starts", starts, s0 + 3);
    chk("R7 early flags in continuous run", earlies, e0 + 2);

    // R9 power-down
    s0 = starts; e0 = earlies;
    test_word = 12'h0F0;
    pwr_dn = 1; cyc(3); cs_n = 0; rc_n = 0; cyc(15);
    chk("R9 no start in power-down", starts, s0);
    chk("R9 busy high", busy_n, 1);
    chk("R9 result kept", result, 12'h2AA);
    push(12'h0F0);
    pwr_dn = 0; cyc(5); cs_n = 1; rc_n = 1; cyc(30);
    chk("R9 start after release", starts, s0 + 1);
    chk("R9 new result", result, 12'h0F0);
    chk("R7 no flag after long gap", earlies, e0);

    chk("R4 scoreboard drained", expq.size(), 0);
    done = 1;
    summary();
  end
endmodule